// File: doc/BRIEF.md
# Atomic Memory Unit with Link Reservations

This block sits in front of a small word-addressed RAM that several requesters share. It carries out every access indivisibly, in a single cycle. The supported operations are plain load and store, atomic swap, test-and-set, fetch-and-increment, and a load-linked / store-conditional pair. Software builds spin locks on these operations. Zero means free and one means held. A swap or test-and-set that returns zero means the lock was taken, and a plain store of zero releases it.

Each requester has one link reservation. A load-linked sets that reservation. Any write to the linked word by a different requester clears it. A store-conditional commits only while its own reservation still covers the address.

When several requesters ask in the same cycle, the lowest index is served first, one per cycle. Each response returns the old word or a success flag to the requester that was served.

Top module: `amu_top`

## Requirements
- R1: After reset every memory word reads 0, and `gnt_o` and `rsp_valid_o` are all 0.
- R2: Op code 0 (load) returns the addressed word and leaves it unchanged. Op code 1 (store) writes the request data and returns 0.
- R3: Op code 2 (swap) writes the request data and returns the previous word.
- R4: Op code 3 (test-and-set) returns the previous word. It writes 1 only if that word was 0, and otherwise leaves the word unchanged.
- R5: Op code 4 (fetch-and-increment) returns the previous word and stores that value plus one, wrapping modulo 2^DW.
- R6: Op code 5 (load-linked) returns the word and sets the requester's reservation to that address. Any earlier reservation of that requester is replaced.
- R7: Op code 6 (store-conditional) with a valid reservation on the same address writes the data and returns 1.
- R8: A store-conditional with no reservation, or with a reservation on another address, writes nothing and returns 0. Every store-conditional, whether it succeeds or fails, clears the issuer's reservation.
- R9: A store, swap, test-and-set, fetch-and-increment or successful store-conditional clears the reservations that other requesters hold on that address. A requester's own write other than a store-conditional keeps its own reservation.
- R10: `gnt_o` is combinational and one-hot or zero. Among the requesters whose `req_valid_i` is high, the lowest index is granted in the same cycle.
- R11: `rsp_valid_o[i]` is high exactly in the cycle after requester i was granted, and `rsp_data_o` then holds its result.
- R12: Op code 7 is reserved and behaves as a load: it returns the word, changes no memory and touches no reservation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | N_REQ | Request pending, one bit per requester, held until granted |
| req_op_i | input | 3*N_REQ | Operation code per requester |
| req_addr_i | input | AW*N_REQ | Word address per requester |
| req_wdata_i | input | DW*N_REQ | Write data per requester |
| gnt_o | output | N_REQ | Request accepted this cycle |
| rsp_valid_o | output | N_REQ | Result valid for that requester |
| rsp_data_o | output | DW | Old word or success flag |

## Verification
The assertions assume that a requester keeps `req_valid_i` high, with its op, address and data stable, until it sees its grant. They also assume the requester drops the request after that edge unless it issues another operation. The bench follows this rule: it changes inputs only on the falling edge, and it releases a request on the falling edge that follows the grant. A long pseudo-random sweep concentrates on four addresses so that reservations collide often. A separate contention test raises all requests at once to observe the priority order.

// File: rtl/amu_pkg.sv
package amu_pkg;
  localparam int unsigned OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_LOAD  = 3'd0,
    OP_STORE = 3'd1,
    OP_SWAP  = 3'd2,
    OP_TAS   = 3'd3,
    OP_FINC  = 3'd4,
    OP_LL    = 3'd5,
    OP_SC    = 3'd6,
    OP_RSV   = 3'd7
  } amu_op_e;
endpackage

// File: rtl/amu_arbiter.sv
module amu_arbiter #(
  parameter int unsigned N_REQ = 4,
  localparam int unsigned IW = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic [N_REQ-1:0] req_i,
  output logic [N_REQ-1:0] gnt_o,
  output logic [IW-1:0]    idx_o,
  output logic             any_o
);
  always_comb begin
    gnt_o = '0;
    idx_o = '0;
    any_o = 1'b0;
    for (int i = 0; i < N_REQ; i++) begin
      if (req_i[i] && !any_o) begin
        gnt_o[i] = 1'b1;
        idx_o    = IW'(i);
        any_o    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/amu_alu.sv
module amu_alu
  import amu_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  amu_op_e       op_i,
  input  logic [DW-1:0] old_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          link_ok_i,
  output logic          we_o,
  output logic [DW-1:0] new_o,
  output logic [DW-1:0] rsp_o,
  output logic          set_link_o,
  output logic          drop_own_o,
  output logic          clr_others_o
);
  always_comb begin
    we_o       = 1'b0;
    new_o      = wdata_i;
    rsp_o      = old_i;
    set_link_o = 1'b0;
    drop_own_o = 1'b0;
    unique case (op_i)
      OP_STORE: begin
        we_o  = 1'b1;
        rsp_o = '0;
      end
      OP_SWAP: we_o = 1'b1;
      OP_TAS: begin
        we_o  = (old_i == '0);
        new_o = DW'(1);
      end
      OP_FINC: begin
        we_o  = 1'b1;
        new_o = old_i + DW'(1);
      end
      OP_LL: set_link_o = 1'b1;
      OP_SC: begin
        we_o       = link_ok_i;
        rsp_o      = DW'(link_ok_i);
        drop_own_o = 1'b1;
      end
      default: ;
    endcase
    // TAS clears other links even when the word was already set
    clr_others_o = we_o || (op_i == OP_TAS);
  end
endmodule

// File: rtl/amu_link_table.sv
module amu_link_table #(
  parameter int unsigned N_REQ = 4,
  parameter int unsigned AW    = 4,
  localparam int unsigned IW = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          acc_i,
  input  logic [IW-1:0] id_i,
  input  logic [AW-1:0] addr_i,
  input  logic          set_link_i,
  input  logic          drop_own_i,
  input  logic          clr_others_i,
  output logic          link_ok_o
);
  logic [N_REQ-1:0]         vld_q;
  logic [N_REQ-1:0][AW-1:0] adr_q;

  for (genvar g = 0; g < N_REQ; g++) begin : g_entry
    logic mine;
    assign mine = acc_i && (id_i == IW'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[g] <= 1'b0;
        adr_q[g] <= '0;
      end else if (mine && set_link_i) begin
        vld_q[g] <= 1'b1;
        adr_q[g] <= addr_i;
      end else if (mine && drop_own_i) begin
        vld_q[g] <= 1'b0;
      end else if (acc_i && !mine && clr_others_i && adr_q[g] == addr_i) begin
        vld_q[g] <= 1'b0;
      end
    end
  end

  assign link_ok_o = vld_q[id_i] && (adr_q[id_i] == addr_i);
endmodule

// File: rtl/amu_top.sv
module amu_top
  import amu_pkg::*;
#(
  parameter int unsigned N_REQ = 4,
  parameter int unsigned AW    = 4,
  parameter int unsigned DW    = 8,
  localparam int unsigned DEPTH = 1 << AW,
  localparam int unsigned IW = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [N_REQ-1:0]      req_valid_i,
  input  logic [N_REQ*OP_W-1:0] req_op_i,
  input  logic [N_REQ*AW-1:0]   req_addr_i,
  input  logic [N_REQ*DW-1:0]   req_wdata_i,
  output logic [N_REQ-1:0]      gnt_o,
  output logic [N_REQ-1:0]      rsp_valid_o,
  output logic [DW-1:0]         rsp_data_o
);
  logic [IW-1:0]    sel;
  logic             any;
  amu_op_e          op;
  logic [AW-1:0]    addr;
  logic [DW-1:0]    wdata, old_word, new_word, rsp_word;
  logic             link_ok, we, set_link, drop_own, clr_others;
  logic [DEPTH-1:0][DW-1:0] mem_q;
  logic [N_REQ-1:0] rsp_valid_q;
  logic [DW-1:0]    rsp_data_q;

  amu_arbiter #(.N_REQ(N_REQ)) u_arb (
    .req_i (req_valid_i),
    .gnt_o (gnt_o),
    .idx_o (sel),
    .any_o (any)
  );

  assign op       = amu_op_e'(req_op_i[sel*OP_W +: OP_W]);
  assign addr     = req_addr_i[sel*AW +: AW];
  assign wdata    = req_wdata_i[sel*DW +: DW];
  assign old_word = mem_q[addr];

  amu_link_table #(.N_REQ(N_REQ), .AW(AW)) u_links (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .acc_i        (any),
    .id_i         (sel),
    .addr_i       (addr),
    .set_link_i   (set_link),
    .drop_own_i   (drop_own),
    .clr_others_i (clr_others),
    .link_ok_o    (link_ok)
  );

  amu_alu #(.DW(DW)) u_alu (
    .op_i         (op),
    .old_i        (old_word),
    .wdata_i      (wdata),
    .link_ok_i    (link_ok),
    .we_o         (we),
    .new_o        (new_word),
    .rsp_o        (rsp_word),
    .set_link_o   (set_link),
    .drop_own_o   (drop_own),
    .clr_others_o (clr_others)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= '0;
    end else if (any && we) begin
      mem_q[addr] <= new_word;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= '0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= gnt_o;
      if (any) rsp_data_q <= rsp_word;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_data_o  = rsp_data_q;
endmodule

// File: rtl/amu_checker.sv
module amu_checker #(
  parameter int unsigned N_REQ = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_REQ-1:0] req_valid_i,
  input logic [N_REQ-1:0] gnt_o,
  input logic [N_REQ-1:0] rsp_valid_o
);
  assert_gnt_onehot_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));

  assert_gnt_requested_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o & ~req_valid_i) == '0);

  assert_gnt_lowest_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|gnt_o) |-> ((req_valid_i & (gnt_o - 1'b1)) == '0));

  assert_no_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|req_valid_i) |-> (|gnt_o));

  assert_rsp_after_gnt_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|gnt_o) |=> (rsp_valid_o == $past(gnt_o)));

  assert_no_rsp_unasked_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|gnt_o) |=> (rsp_valid_o == '0));
endmodule

bind amu_top amu_checker #(.N_REQ(N_REQ)) u_amu_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .gnt_o       (gnt_o),
  .rsp_valid_o (rsp_valid_o)
);

// File: tb/test_amu_top.sv
module test_amu_top;
  localparam int N  = 4;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int D  = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]    req_valid = '0;
  logic [N*3-1:0]  req_op = '0;
  logic [N*AW-1:0] req_addr = '0;
  logic [N*DW-1:0] req_wdata = '0;
  logic [N-1:0]    gnt, rsp_valid;
  logic [DW-1:0]   rsp_data;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  logic [DW-1:0] m_mem [D];
  bit            m_vld [N];
  int            m_adr [N];
  logic [31:0]   rng = 32'h1234_5678;

  always #10 clk = ~clk;

  amu_top #(.N_REQ(N), .AW(AW), .DW(DW)) i_amu_top (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_op_i(req_op),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .gnt_o(gnt),
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input int op);
    case (op)
      0: return "R2 load";
      1: return "R2 store";
      2: return "R3 swap";
      3: return "R4 tas";
      4: return "R5 finc";
      5: return "R6 ll";
      6: return "R7/R8 sc";
      default: return "R12 reserved";
    endcase
  endfunction

  // Reference model from the requirements
  task automatic model(input int id, input int op, input int a, input logic [DW-1:0] wd,
                       output logic [DW-1:0] exp);
    logic [DW-1:0] old;
    bit wr, clr;
    old = m_mem[a];
    exp = old;
    wr = 0;
    clr = 0;
    case (op)
      1: begin m_mem[a] = wd; exp = '0; wr = 1; end
      2: begin m_mem[a] = wd; wr = 1; end
      3: begin if (old == '0) m_mem[a] = 1; clr = 1; end
      4: begin m_mem[a] = old + 1'b1; wr = 1; end
      5: begin m_vld[id] = 1; m_adr[id] = a; end
      6: begin
        if (m_vld[id] && m_adr[id] == a) begin m_mem[a] = wd; exp = 1; wr = 1; end
        else exp = 0;
        m_vld[id] = 0;
      end
      default: ;
    endcase
    if (wr || clr)
      for (int k = 0; k < N; k++)
        if (k != id && m_vld[k] && m_adr[k] == a) m_vld[k] = 0;
  endtask

  task automatic issue(input int id, input int op, input int a, input logic [DW-1:0] wd,
                       output logic [DW-1:0] got);
    @(negedge clk);
    req_valid[id] = 1'b1;
    req_op[id*3 +: 3] = 3'(op);
    req_addr[id*AW +: AW] = AW'(a);
    req_wdata[id*DW +: DW] = wd;
    #1;
    while (!gnt[id]) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    req_valid[id] = 1'b0;
    #1;
    check(rsp_valid == (N'(1) << id), "R11 rsp_valid", int'(rsp_valid), 1 << id);
    got = rsp_data;
  endtask

  task automatic op_chk(input int id, input int op, input int a, input logic [DW-1:0] wd);
    logic [DW-1:0] got, exp;
    issue(id, op, a, wd, got);
    model(id, op, a, wd, exp);
    check(got == exp, tag_of(op), int'(got), int'(exp));
  endtask

  initial begin
    int wd0;
    for (int i = 0; i < D; i++) m_mem[i] = '0;
    for (int i = 0; i < N; i++) begin m_vld[i] = 0; m_adr[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(gnt == '0 && rsp_valid == '0, "R1 idle outputs", int'({gnt, rsp_valid}), 0);
    for (int a = 0; a < D; a++) op_chk(a % N, 0, a, '0);

    // targeted link cases
    op_chk(1, 5, 5, 8'h00);
    op_chk(1, 6, 5, 8'h33);   // R7 success
    op_chk(1, 0, 5, 8'h00);
    op_chk(1, 6, 5, 8'h44);   // R8 reservation consumed
    op_chk(2, 5, 7, 8'h00);
    op_chk(2, 6, 8, 8'h55);   // R8 other address
    op_chk(2, 0, 8, 8'h00);
    op_chk(0, 5, 6, 8'h00);
    op_chk(2, 5, 6, 8'h00);
    op_chk(2, 1, 6, 8'h21);   // R9 own store keeps own link
    op_chk(0, 6, 6, 8'h66);   // R9 lost to other's store
    op_chk(2, 6, 6, 8'h77);   // R9 own link survives
    op_chk(3, 5, 9, 8'h00);
    op_chk(0, 3, 9, 8'h00);   // R9 TAS clears
    op_chk(3, 6, 9, 8'h10);
    op_chk(3, 3, 9, 8'h00);   // R4 already set
    op_chk(1, 4, 10, 8'hff);
    op_chk(1, 2, 10, 8'hff);
    op_chk(1, 4, 10, 8'h00);  // R5 wrap
    op_chk(1, 0, 10, 8'h00);
    op_chk(0, 7, 10, 8'h99);  // R12
    op_chk(0, 0, 10, 8'h00);

    // R10 contention: all four FINC on one word
    wd0 = int'(m_mem[11]);
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      req_op[i*3 +: 3] = 3'd4;
      req_addr[i*AW +: AW] = AW'(11);
    end
    req_valid = '1;
    #1;
    for (int k = 0; k < N; k++) begin
      check(gnt == (N'(1) << k), "R10 priority", int'(gnt), 1 << k);
      @(posedge clk);
      @(negedge clk);
      req_valid[k] = 1'b0;
      #1;
      check(rsp_valid == (N'(1) << k), "R11 rsp order", int'(rsp_valid), 1 << k);
      check(rsp_data == DW'(wd0 + k), "R10 serial finc", int'(rsp_data), (wd0 + k) % 256);
      m_mem[11] = m_mem[11] + 1'b1;
    end

    // pseudo-random sweep over four hot addresses
    for (int it = 0; it < 1500; it++) begin
      int id, op, a;
      rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
      id = int'(rng[1:0]);
      op = int'(rng[6:4]);
      if (rng[7]) op = rng[8] ? 5 : 6;
      a = int'(rng[10:9]);
      op_chk(id, op, a, rng[23:16]);
    end

    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule